// File: doc/BRIEF.md
# Timer Run and External Interrupt Flag Register

This block is the eight-bit control and status register that sits between a small microcontroller core, its two timers and its two external interrupt pins. Software writes it either as a whole byte or one bit at a time. The register holds a run enable for each timer, which drives the timer directly. It also holds an overflow flag for each timer, which the timer sets and which is cleared by software or by the interrupt controller's acknowledge.

Each external pin passes through a synchronizer and then a polarity correction. A per-pin type bit then picks how that pin's request flag behaves. In edge mode the flag latches on an inactive-to-active transition and is cleared by software or by acknowledge. In level mode the flag simply follows the pin and ignores both clearing paths. When hardware raises a flag in the same cycle that software or the interrupt controller clears it, the set is kept, so no event is lost.

Top module: `tmr_xint_ctl`

## Requirements
- R1: After reset `rdData` is 0x00, both `tmrRun` bits are 0 and both flag outputs are 0.
- R2: A byte write updates all eight bits, and the new value reads back after the next rising edge. The bit layout is: bit 7 timer-1 flag, bit 6 timer-1 run, bit 5 timer-0 flag, bit 4 timer-0 run, bit 3 pin-1 flag, bit 2 pin-1 type, bit 1 pin-0 flag, bit 0 pin-0 type.
- R3: A bit write changes only the bit at `wrBitIdx` to `wrBitVal`. If a byte write happens in the same cycle, the byte write wins.
- R4: A one-cycle pulse on `tmrOvf[n]` sets the timer-n flag at the next rising edge.
- R5: `ackTmr[n]` clears the timer-n flag, and a software write of 0 also clears it.
- R6: `tmrRun[n]` equals the timer-n run bit. `tmrFlag[n]` and `extFlag[n]` equal the timer-n flag and the pin-n flag as read back.
- R7: With the type bit at 1 (edge mode), an inactive-to-active change on `xPin[n]` sets the pin-n flag at the third rising edge after the pin changes, and not before. The flag stays set while the pin stays active, and `ackExt[n]` or a software write of 0 clears it.
- R8: With the type bit at 0 (level mode), the pin-n flag reads 1 from the second rising edge after the pin becomes active until the second rising edge after it becomes inactive. `ackExt[n]` and software writes have no effect on it.
- R9: `xActHigh[n]`=1 makes a high level on pin n active, and 0 makes a low level active. This applies in both modes.
- R10: A hardware set in the same cycle as an acknowledge or a software clear of the same flag leaves the flag at 1.
- R11: While a pin is in level mode, its edge latch is held clear. A write of 1 to the flag bit with the type bit at 0 therefore reads back as the pin level, and switching to edge mode starts with a clear flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| wrByteEn | input | 1 | Byte write strobe |
| wrByteData | input | 8 | Byte write data |
| wrBitEn | input | 1 | Single-bit write strobe |
| wrBitIdx | input | 3 | Bit index for single-bit write |
| wrBitVal | input | 1 | Value for single-bit write |
| tmrOvf | input | 2 | Overflow pulse per timer |
| ackTmr | input | 2 | Timer interrupt acknowledge per timer |
| ackExt | input | 2 | External interrupt acknowledge per pin |
| xPin | input | 2 | Raw asynchronous external interrupt pins |
| xActHigh | input | 2 | Pin polarity: 1 active high, 0 active low |
| rdData | output | 8 | Register readback |
| tmrRun | output | 2 | Timer run enables |
| tmrFlag | output | 2 | Timer overflow request flags |
| extFlag | output | 2 | External interrupt request flags |

## Verification
Two functions can fall in the same cycle: a hardware set of a flag, and a clear of that same flag by an acknowledge or a software write. For the timer flags, the bench provokes this by driving an overflow pulse together with an acknowledge, and separately together with a byte write of zero. For an edge-mode pin, it times a bit write of 0 together with `ackExt` to land in the exact cycle the synchronized edge is detected, which is two rising edges after the pin changes. In every case the flag must read 1 on the following cycle, and a later plain clear must still take it to 0.

// File: rtl/tmr_xint_pkg.sv
package tmr_xint_pkg;
  localparam int unsigned XCH   = 2;
  localparam int unsigned REG_W = 4 * XCH;
  localparam int unsigned IDX_W = $clog2(REG_W);

  // timer bits occupy the upper half, pin bits the lower half
  function automatic int unsigned tfPos(input int unsigned n);
    return 2 * XCH + 2 * n + 1;
  endfunction
  function automatic int unsigned trPos(input int unsigned n);
    return 2 * XCH + 2 * n;
  endfunction
  function automatic int unsigned iePos(input int unsigned n);
    return 2 * n + 1;
  endfunction
  function automatic int unsigned itPos(input int unsigned n);
    return 2 * n;
  endfunction

  typedef struct packed {
    logic [REG_W-1:0] wrMask;
    logic [REG_W-1:0] wrVal;
    logic [XCH-1:0]   tfSet;
    logic [XCH-1:0]   tfAck;
    logic [XCH-1:0]   ieSet;
    logic [XCH-1:0]   ieAck;
    logic [XCH-1:0]   extAct;
  } strobe_t;
endpackage

// File: rtl/tmr_xint_ctrl.sv
module tmr_xint_ctrl
  import tmr_xint_pkg::*;
#(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             wrByteEn,
  input  logic [REG_W-1:0] wrByteData,
  input  logic             wrBitEn,
  input  logic [IDX_W-1:0] wrBitIdx,
  input  logic             wrBitVal,
  input  logic [XCH-1:0]   tmrOvf,
  input  logic [XCH-1:0]   ackTmr,
  input  logic [XCH-1:0]   ackExt,
  input  logic [XCH-1:0]   xPin,
  input  logic [XCH-1:0]   xActHigh,
  output strobe_t          stb
);
  localparam int unsigned TOP = SYNC_STAGES - 1;

  logic [XCH-1:0][SYNC_STAGES-1:0] syncQ;
  logic [XCH-1:0] actNow;
  logic [XCH-1:0] actPrev;
  logic [XCH-1:0] edgeHit;

  // write decode: byte write has priority over bit write
  always_comb begin
    stb.wrMask = '0;
    stb.wrVal  = '0;
    if (wrByteEn) begin
      stb.wrMask = '1;
      stb.wrVal  = wrByteData;
    end else if (wrBitEn) begin
      stb.wrMask[wrBitIdx] = 1'b1;
      stb.wrVal[wrBitIdx]  = wrBitVal;
    end
  end

  for (genvar n = 0; n < XCH; n++) begin : g_pin
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        syncQ[n] <= '0;
        // starting "active" suppresses a false edge when a pin idles active
        actPrev[n] <= 1'b1;
      end else begin
        syncQ[n] <= {syncQ[n][SYNC_STAGES-2:0], xPin[n]};
        actPrev[n] <= actNow[n];
      end
    end

    assign actNow[n]  = syncQ[n][TOP] ~^ xActHigh[n];
    assign edgeHit[n] = actNow[n] & ~actPrev[n];

    // R7: a detected edge cannot repeat on the very next cycle
    a_r7_edge_single: assert property (@(posedge clk) disable iff (!rstN)
      edgeHit[n] |=> !edgeHit[n]);
  end

  assign stb.tfSet  = tmrOvf;
  assign stb.tfAck  = ackTmr;
  assign stb.ieSet  = edgeHit;
  assign stb.ieAck  = ackExt;
  assign stb.extAct = actNow;
endmodule

// File: rtl/tmr_xint_dp.sv
module tmr_xint_dp
  import tmr_xint_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  strobe_t          stb,
  output logic [REG_W-1:0] rdData,
  output logic [XCH-1:0]   tmrRun,
  output logic [XCH-1:0]   tmrFlag,
  output logic [XCH-1:0]   extFlag
);
  logic [XCH-1:0] tfQ, trQ, ieQ, itQ;
  logic [XCH-1:0] itNext, ieVis;

  for (genvar n = 0; n < XCH; n++) begin : g_ch
    localparam int unsigned TF = tfPos(n);
    localparam int unsigned TR = trPos(n);
    localparam int unsigned IE = iePos(n);
    localparam int unsigned IT = itPos(n);

    assign itNext[n] = stb.wrMask[IT] ? stb.wrVal[IT] : itQ[n];
    assign ieVis[n]  = itQ[n] ? ieQ[n] : stb.extAct[n];

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        tfQ[n] <= 1'b0;
        trQ[n] <= 1'b0;
        ieQ[n] <= 1'b0;
        itQ[n] <= 1'b0;
      end else begin
        trQ[n] <= stb.wrMask[TR] ? stb.wrVal[TR] : trQ[n];
        itQ[n] <= itNext[n];
        // hardware set > software write > acknowledge
        if (stb.tfSet[n])       tfQ[n] <= 1'b1;
        else if (stb.wrMask[TF]) tfQ[n] <= stb.wrVal[TF];
        else if (stb.tfAck[n])  tfQ[n] <= 1'b0;
        if (!itNext[n])          ieQ[n] <= 1'b0;
        else if (stb.ieSet[n])   ieQ[n] <= 1'b1;
        else if (stb.wrMask[IE]) ieQ[n] <= stb.wrVal[IE];
        else if (stb.ieAck[n])   ieQ[n] <= 1'b0;
      end
    end

    a_r4_ovf_sets: assert property (@(posedge clk) disable iff (!rstN)
      stb.tfSet[n] |=> tfQ[n]);
    a_r5_ack_clears: assert property (@(posedge clk) disable iff (!rstN)
      stb.tfAck[n] && !stb.tfSet[n] && !stb.wrMask[TF] |=> !tfQ[n]);
    a_r6_run_holds: assert property (@(posedge clk) disable iff (!rstN)
      !stb.wrMask[TR] |=> $stable(trQ[n]));
    a_r10_edge_set_wins: assert property (@(posedge clk) disable iff (!rstN)
      stb.ieSet[n] && itQ[n] && !(stb.wrMask[IT] && !stb.wrVal[IT]) |=> ieQ[n]);
    a_r11_level_latch_clear: assert property (@(posedge clk) disable iff (!rstN)
      !itQ[n] && !stb.wrMask[IT] |=> !ieQ[n]);
  end

  always_comb begin
    rdData = '0;
    for (int n = 0; n < XCH; n++) begin
      rdData[tfPos(n)] = tfQ[n];
      rdData[trPos(n)] = trQ[n];
      rdData[iePos(n)] = ieVis[n];
      rdData[itPos(n)] = itQ[n];
    end
  end

  assign tmrRun  = trQ;
  assign tmrFlag = tfQ;
  assign extFlag = ieVis;
endmodule

// File: rtl/tmr_xint_ctl.sv
module tmr_xint_ctl
  import tmr_xint_pkg::*;
#(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic         wrByteEn,
  input  logic [7:0]   wrByteData,
  input  logic         wrBitEn,
  input  logic [2:0]   wrBitIdx,
  input  logic         wrBitVal,
  input  logic [1:0]   tmrOvf,
  input  logic [1:0]   ackTmr,
  input  logic [1:0]   ackExt,
  input  logic [1:0]   xPin,
  input  logic [1:0]   xActHigh,
  output logic [7:0]   rdData,
  output logic [1:0]   tmrRun,
  output logic [1:0]   tmrFlag,
  output logic [1:0]   extFlag
);
  strobe_t stb;

  tmr_xint_ctrl #(.SYNC_STAGES(SYNC_STAGES)) ctrl_i (
    .clk(clk), .rstN(rstN),
    .wrByteEn(wrByteEn), .wrByteData(wrByteData),
    .wrBitEn(wrBitEn), .wrBitIdx(wrBitIdx), .wrBitVal(wrBitVal),
    .tmrOvf(tmrOvf), .ackTmr(ackTmr), .ackExt(ackExt),
    .xPin(xPin), .xActHigh(xActHigh),
    .stb(stb)
  );

  tmr_xint_dp dp_i (
    .clk(clk), .rstN(rstN), .stb(stb),
    .rdData(rdData), .tmrRun(tmrRun), .tmrFlag(tmrFlag), .extFlag(extFlag)
  );
endmodule

// File: tb/tmr_xint_ctl_tb.sv
module tmr_xint_ctl_tb_top;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic wrByteEn = 0, wrBitEn = 0, wrBitVal = 0;
  logic [7:0] wrByteData = '0;
  logic [2:0] wrBitIdx = '0;
  logic [1:0] tmrOvf = '0, ackTmr = '0, ackExt = '0, xPin = '0, xActHigh = 2'b11;
  logic [7:0] rdData;
  logic [1:0] tmrRun, tmrFlag, extFlag;
  int checks = 0, fails = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  tmr_xint_ctl dut_i (
    .clk(clk), .rstN(rstN), .wrByteEn(wrByteEn), .wrByteData(wrByteData),
    .wrBitEn(wrBitEn), .wrBitIdx(wrBitIdx), .wrBitVal(wrBitVal),
    .tmrOvf(tmrOvf), .ackTmr(ackTmr), .ackExt(ackExt),
    .xPin(xPin), .xActHigh(xActHigh),
    .rdData(rdData), .tmrRun(tmrRun), .tmrFlag(tmrFlag), .extFlag(extFlag)
  );

  task automatic step(int k = 1);
    for (int i = 0; i < k; i++) begin @(posedge clk); #1; end
  endtask

  task automatic chk(string tag, logic [7:0] got, logic [7:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s got %02h expected %02h", tag, got, exp);
    end
  endtask

  task automatic wrByte(logic [7:0] v);
    wrByteEn = 1; wrByteData = v; step(); wrByteEn = 0;
  endtask

  task automatic wrBit(int idx, logic v);
    wrBitEn = 1; wrBitIdx = 3'(idx); wrBitVal = v; step(); wrBitEn = 0;
  endtask

  initial begin
    #(5.0 * 200000);
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    logic [7:0] e;
    step(2);
    chk("R1 reset readback", rdData, 8'h00);
    rstN = 1; step();
    chk("R1 reset outputs", {tmrRun, tmrFlag, extFlag}, 8'h00);

    // R2/R6/R11: byte sweep with pins inactive
    for (int v = 0; v < 256; v++) begin
      wrByte(8'(v));
      e = 8'(v);
      if (!e[0]) e[1] = 0;
      if (!e[2]) e[3] = 0;
      chk("R2 R11 byte write", rdData, e);
      chk("R6 mirrors", {2'b00, tmrRun, tmrFlag, extFlag},
          {2'b00, e[6], e[4], e[7], e[5], e[3], e[1]});
    end

    // R3: single-bit writes
    wrByte(8'h00);
    for (int i = 0; i < 8; i++) begin
      e = 8'(1 << i);
      if (i == 1 || i == 3) e = 8'h00;
      wrBit(i, 1); chk("R3 bit set", rdData, e);
      wrBit(i, 0); chk("R3 bit clear", rdData, 8'h00);
    end
    wrByte(8'h05);
    wrBitEn = 1; wrBitIdx = 3'd6; wrBitVal = 1; wrByte(8'h10); wrBitEn = 0;
    chk("R3 byte beats bit", rdData, 8'h10);
    wrByte(8'h00);

    // R4/R5/R10: timer flags
    for (int n = 0; n < 2; n++) begin
      e = 8'(1 << (5 + 2 * n));
      tmrOvf[n] = 1; step(); tmrOvf = 0;
      chk("R4 ovf sets", rdData, e);
      ackTmr[n] = 1; step(); ackTmr = 0;
      chk("R5 ack clears", rdData, 8'h00);
      tmrOvf[n] = 1; step(); tmrOvf = 0;
      wrBit(5 + 2 * n, 0);
      chk("R5 sw clears", rdData, 8'h00);
      tmrOvf[n] = 1; ackTmr[n] = 1; step(); tmrOvf = 0; ackTmr = 0;
      chk("R10 set beats ack", rdData, e);
      tmrOvf[n] = 1; wrByte(8'h00); tmrOvf = 0;
      chk("R10 set beats write", rdData, e);
      wrByte(8'h00);
    end

    // R7/R9/R10: edge mode, both polarities
    for (int n = 0; n < 2; n++)
      for (int pol = 0; pol < 2; pol++) begin
        logic [7:0] itb, ieb;
        itb = 8'(1 << (2 * n)); ieb = 8'(1 << (2 * n + 1));
        wrByte(8'h00);
        xActHigh[n] = pol[0]; xPin[n] = ~pol[0]; step(3);
        wrBit(2 * n, 1);
        chk("R9 idle inactive", rdData, itb);
        xPin[n] = pol[0]; step(2);
        chk("R7 not before third edge", rdData, itb);
        step();
        chk("R7 R9 edge sets", rdData, itb | ieb);
        step(3);
        chk("R7 holds while active", {6'b0, extFlag}, 8'(1 << n));
        ackExt[n] = 1; step(); ackExt = 0;
        chk("R7 ack clears", rdData, itb);
        step(2);
        chk("R7 no retrigger on level", rdData, itb);
        xPin[n] = ~pol[0]; step(3);
        xPin[n] = pol[0]; step(3);
        chk("R7 second edge", rdData, itb | ieb);
        wrBit(2 * n + 1, 0);
        chk("R7 sw clears", rdData, itb);
        xPin[n] = ~pol[0]; step(3);
        xPin[n] = pol[0]; step(2);
        wrBitEn = 1; wrBitIdx = 3'(2 * n + 1); wrBitVal = 0; ackExt[n] = 1;
        step(); wrBitEn = 0; ackExt = 0;
        chk("R10 edge beats clear", rdData, itb | ieb);
        wrBit(2 * n + 1, 0);
        chk("R10 later clear", rdData, itb);
        wrByte(8'h00);
        xActHigh[n] = 1; xPin[n] = 0; step(3);
      end

    // R8/R9/R11: level mode
    for (int n = 0; n < 2; n++)
      for (int pol = 0; pol < 2; pol++) begin
        logic [7:0] ieb;
        ieb = 8'(1 << (2 * n + 1));
        wrByte(8'h00);
        xActHigh[n] = pol[0]; xPin[n] = ~pol[0]; step(3);
        wrBit(2 * n + 1, 1);
        chk("R11 level write ignored", rdData, 8'h00);
        xPin[n] = pol[0]; step();
        chk("R8 not before second edge", rdData, 8'h00);
        step();
        chk("R8 R9 level follows", rdData, ieb);
        ackExt[n] = 1; step(); ackExt = 0;
        chk("R8 ack ignored", rdData, ieb);
        wrBit(2 * n + 1, 0);
        chk("R8 write ignored", rdData, ieb);
        xPin[n] = ~pol[0]; step();
        chk("R8 still active one edge", rdData, ieb);
        step();
        chk("R8 level drops", rdData, 8'h00);
        wrBit(2 * n, 1);
        chk("R11 edge mode starts clear", rdData, 8'(1 << (2 * n)));
        wrByte(8'h00);
        xActHigh[n] = 1; xPin[n] = 0; step(3);
      end

    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule